// File: doc/BRIEF.md
# Single-Wire Half-Duplex UART

This block is a byte-oriented asynchronous serial port that can run either with separate transmit and receive wires or with both directions sharing one bidirectional line. A mode input picks between the two. In shared-line operation the receiver listens on the same pad the transmitter drives. The pad driver is enabled only while a frame is being sent. At all other times the line is left to the far end or to a pull-up, so the pad acts as an input while the block is idle or receiving.

The host side has a valid/ready transmit port and a pulsed receive port. Status outputs report a bad mode combination, bit collisions seen during its own transmission, and framing errors. A frame is one start bit, eight data bits sent least significant first, and one stop bit. Each bit lasts `BIT_CLKS` clock cycles. Several mode enables for other line disciplines exist only as inputs here. They must all be clear while the shared line is in use, and setting any of them together with shared-line mode is reported as an error.

Top module: `uart_sw_half`

## Requirements
- R1: In full-duplex mode (`cfg_half`=0) `line_oe` is 1 at all times. `line_out` is 1 when idle. A frame starts in the cycle after `tx_valid` and `tx_ready` are both 1 at a clock edge and has this shape: a 0 start bit, then data bits 0 to 7, then a 1 stop bit, each held for `BIT_CLKS` cycles. `tx_ready` is 0 while a frame is in flight.
- R2: In full-duplex mode the receiver takes its input from `rx_pin`, and `line_in` has no effect on received data.
- R3: In shared-line mode the receiver takes its input from `line_in`, and `rx_pin` has no effect.
- R4: In shared-line mode `line_oe` is 1 from the first cycle of the start bit through the last cycle of the stop bit, and 0 in every other cycle.
- R5: When `cfg_half`=1 and any of `cfg_lin`, `cfg_clk_out`, `cfg_smartcard` or `cfg_irda` is 1, `cfg_err` is 1, `line_oe` is 0 and `tx_ready` is 0. In full-duplex mode those inputs never raise `cfg_err`.
- R6: In shared-line mode a frame whose start is detected while the block is transmitting is its own echo. It appears on `rx_data`/`rx_valid` when `cfg_keep_echo`=1 and is discarded when `cfg_keep_echo`=0.
- R7: In shared-line mode `tx_ready` is 0 while the receiver is busy with a frame, so a pending transmission waits until the receiver returns to idle.
- R8: In shared-line mode, `tx_collision` pulses for one cycle for each transmitted bit whose value sampled back from the line at mid-bit differs from the value sent. It never pulses in full-duplex mode.
- R9: `rx_valid` pulses for one cycle with the byte after a stop bit sampled as 1. A stop bit sampled as 0 gives a one-cycle `rx_frame_err` pulse and no `rx_valid`.
- R10: After reset in full-duplex mode, `line_oe`=1, `line_out`=1, `tx_ready`=1, and `rx_valid` and `tx_collision` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | 1 | 1 = shared single line, 0 = separate wires |
| cfg_lin | input | 1 | Conflicting mode enable (break-framed bus) |
| cfg_clk_out | input | 1 | Conflicting mode enable (synchronous clock output) |
| cfg_smartcard | input | 1 | Conflicting mode enable (card interface) |
| cfg_irda | input | 1 | Conflicting mode enable (infrared encoding) |
| cfg_keep_echo | input | 1 | 1 = deliver own echoed frames to the receive port |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_frame_err | output | 1 | One-cycle strobe for a bad stop bit |
| rx_pin | input | 1 | Separate receive wire (full-duplex) |
| line_in | input | 1 | Pad input of the data line |
| line_out | output | 1 | Pad output value |
| line_oe | output | 1 | Pad driver enable |
| cfg_err | output | 1 | Illegal mode combination |
| tx_collision | output | 1 | Echoed bit mismatch strobe |
| tx_active | output | 1 | Frame being transmitted |
| rx_active | output | 1 | Frame being received |

## Verification
The transmitter is driven with bytes of mixed bit patterns (0xA5, 0x3C, 0x5A, 0x96, 0xFF, 0x81). A per-cycle model in the bench checks the pad value and pad enable against each one, which confirms the bit order and the exact edges of the driver window in both modes. The receive side is tried four ways: in loopback through the separate wire while `line_in` is held low, with its own echo kept and then dropped, with frames from a far-end talker on the shared line while `rx_pin` is held low, and with one far-end frame whose stop bit is bad. These separate the two input sources and the echo rule from framing checks. A far-end frame is started shortly before a transmit request to show that the request is held off. A forced low bit inside an all-ones frame tells a real collision apart from a clean echo. Mode inputs are then toggled to show which combinations are illegal.

// File: rtl/uhd_pkg.sv
package uhd_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_st_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_st_e;

    typedef struct packed {
        logic half;
        logic lin;
        logic clk_out;
        logic smart;
        logic irda;
        logic keep_echo;
    } mode_cfg_t;

    // Shared-line operation forbids every other line discipline.
    function automatic logic mode_conflict(input mode_cfg_t c);
        return c.half && (c.lin || c.clk_out || c.smart || c.irda);
    endfunction

endpackage

// File: rtl/uhd_line_front.sv
module uhd_line_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic half_sel,
    input  logic rx_pin,
    input  logic line_in,
    output logic line_s
);
    logic raw;
    logic [SYNC_STAGES-1:0] chain;

    // Source select happens before synchronising so a mode change is filtered too.
    assign raw = half_sel ? line_in : rx_pin;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= raw;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[SYNC_STAGES-2:0], raw};
            end
        end
    endgenerate

    assign line_s = chain[SYNC_STAGES-1];
endmodule

// File: rtl/uhd_tx.sv
module uhd_tx
    import uhd_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BIT_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_sel,
    input  logic              cfg_bad,
    input  logic              rx_busy,
    input  logic              line_s,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              ser_out,
    output logic              busy,
    output logic              collide
);
    localparam int CW  = $clog2(BIT_CLKS);
    localparam int BW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(BIT_CLKS - 1);
    localparam logic [CW-1:0] MID_CNT  = CW'(BIT_CLKS / 2);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    tx_st_e            st;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] sh;
    logic              cur_bit;

    always_comb begin
        case (st)
            TX_START: cur_bit = 1'b0;
            TX_DATA:  cur_bit = sh[0];
            default:  cur_bit = 1'b1;
        endcase
    end

    assign tx_ready = (st == TX_IDLE) && !cfg_bad && !(half_sel && rx_busy);
    assign ser_out  = cur_bit;
    assign busy     = (st != TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= TX_IDLE;
            cnt     <= '0;
            bidx    <= '0;
            sh      <= '0;
            collide <= 1'b0;
        end else begin
            collide <= half_sel && (st != TX_IDLE) && (cnt == MID_CNT) && (line_s != cur_bit);
            case (st)
                TX_IDLE: begin
                    if (tx_valid && tx_ready) begin
                        st  <= TX_START;
                        cnt <= '0;
                        sh  <= tx_data;
                    end
                end
                default: begin
                    if (cnt == LAST_CNT) begin
                        cnt <= '0;
                        case (st)
                            TX_START: begin
                                st   <= TX_DATA;
                                bidx <= '0;
                            end
                            TX_DATA: begin
                                sh <= sh >> 1;
                                if (bidx == LAST_BIT) st <= TX_STOP;
                                else                  bidx <= bidx + 1'b1;
                            end
                            default: st <= TX_IDLE;
                        endcase
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uhd_rx.sv
module uhd_rx
    import uhd_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BIT_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_s,
    input  logic              half_sel,
    input  logic              keep_echo,
    input  logic              tx_busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              busy
);
    localparam int CW  = $clog2(BIT_CLKS);
    localparam int BW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(BIT_CLKS - 1);
    localparam logic [CW-1:0] HALF_CNT = CW'(BIT_CLKS / 2 - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    rx_st_e            st;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] sh;
    logic              is_echo;
    logic              deliver;

    assign busy    = (st != RX_IDLE);
    assign deliver = !is_echo || keep_echo;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            sh        <= '0;
            is_echo   <= 1'b0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (!line_s) begin
                        st      <= RX_START;
                        cnt     <= '0;
                        is_echo <= half_sel && tx_busy;
                    end
                end
                RX_START: begin
                    if (cnt == HALF_CNT) begin
                        cnt  <= '0;
                        bidx <= '0;
                        st   <= line_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == LAST_CNT) begin
                        cnt <= '0;
                        sh  <= {line_s, sh[DATA_W-1:1]};
                        if (bidx == LAST_BIT) st <= RX_STOP;
                        else                  bidx <= bidx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == LAST_CNT) begin
                        cnt <= '0;
                        st  <= RX_IDLE;
                        if (deliver) begin
                            if (line_s) begin
                                rx_valid <= 1'b1;
                                rx_data  <= sh;
                            end else begin
                                frame_err <= 1'b1;
                            end
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_sw_half.sv
module uart_sw_half
    import uhd_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int BIT_CLKS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_half,
    input  logic              cfg_lin,
    input  logic              cfg_clk_out,
    input  logic              cfg_smartcard,
    input  logic              cfg_irda,
    input  logic              cfg_keep_echo,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_frame_err,
    input  logic              rx_pin,
    input  logic              line_in,
    output logic              line_out,
    output logic              line_oe,
    output logic              cfg_err,
    output logic              tx_collision,
    output logic              tx_active,
    output logic              rx_active
);
    mode_cfg_t cfg;
    logic      line_s;

    assign cfg = '{half:      cfg_half,
                   lin:       cfg_lin,
                   clk_out:   cfg_clk_out,
                   smart:     cfg_smartcard,
                   irda:      cfg_irda,
                   keep_echo: cfg_keep_echo};

    assign cfg_err = mode_conflict(cfg);

    // Shared line: drive only while a frame is out and the mode set is legal.
    assign line_oe = cfg.half ? (tx_active && !cfg_err) : 1'b1;

    uhd_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst      (rst),
        .half_sel (cfg.half),
        .rx_pin   (rx_pin),
        .line_in  (line_in),
        .line_s   (line_s)
    );

    uhd_tx #(.DATA_W(DATA_W), .BIT_CLKS(BIT_CLKS)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .half_sel (cfg.half),
        .cfg_bad  (cfg_err),
        .rx_busy  (rx_active),
        .line_s   (line_s),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .ser_out  (line_out),
        .busy     (tx_active),
        .collide  (tx_collision)
    );

    uhd_rx #(.DATA_W(DATA_W), .BIT_CLKS(BIT_CLKS)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .line_s    (line_s),
        .half_sel  (cfg.half),
        .keep_echo (cfg.keep_echo),
        .tx_busy   (tx_active),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .frame_err (rx_frame_err),
        .busy      (rx_active)
    );
endmodule

// File: rtl/uhd_checks.sv
module uhd_checks (
    input logic clk,
    input logic rst,
    input logic cfg_half,
    input logic cfg_err,
    input logic line_oe,
    input logic line_out,
    input logic tx_ready,
    input logic tx_active,
    input logic rx_active,
    input logic tx_collision,
    input logic rx_valid,
    input logic rx_frame_err
);
    assert_full_drive_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg_half |-> line_oe);

    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !tx_active);

    assert_idle_release_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_half && !tx_active) |-> !line_oe);

    assert_start_low_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_half && $rose(line_oe)) |-> !line_out);

    assert_stop_high_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_half && $past(cfg_half) && $fell(tx_active)) |-> $past(line_out));

    assert_bad_cfg_release_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!line_oe && !tx_ready));

    assert_defer_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_half && rx_active) |-> !tx_ready);

    assert_collide_half_R8: assert property (@(posedge clk) disable iff (rst)
        tx_collision |-> $past(cfg_half));

    assert_rx_strobes_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_valid, rx_frame_err}));
endmodule

bind uart_sw_half uhd_checks u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_half     (cfg_half),
    .cfg_err      (cfg_err),
    .line_oe      (line_oe),
    .line_out     (line_out),
    .tx_ready     (tx_ready),
    .tx_active    (tx_active),
    .rx_active    (rx_active),
    .tx_collision (tx_collision),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err)
);

// File: tb/sim_uart_sw_half.sv
`timescale 1ns/1ps
module sim_uart_sw_half;
    localparam int B = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_half = 1'b0, cfg_lin = 1'b0, cfg_clk_out = 1'b0;
    logic       cfg_smartcard = 1'b0, cfg_irda = 1'b0, cfg_keep_echo = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid, rx_frame_err;
    logic       rx_pin, line_in, line_out, line_oe;
    logic       cfg_err, tx_collision, tx_active, rx_active;

    logic       ext_line = 1'b1;
    logic       rx_pin_drv = 1'b1;
    logic       loop_full = 1'b0;
    int         ext_phase = -1;

    int tests = 0;
    int fails = 0;
    int col_cnt = 0;
    int fe_cnt = 0;
    int rx_cnt = 0;
    string rx_tag = "R2";
    logic [7:0] exp_q[$];

    int         mt = -1;
    logic [7:0] md = 8'h00;

    always #4 clk = ~clk;

    // Open-drain style wire: any driver pulling low wins.
    assign line_in = (line_oe ? line_out : 1'b1) & ext_line;
    assign rx_pin  = loop_full ? line_out : rx_pin_drv;

    uart_sw_half #(.DATA_W(8), .BIT_CLKS(B), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .cfg_half(cfg_half), .cfg_lin(cfg_lin),
        .cfg_clk_out(cfg_clk_out), .cfg_smartcard(cfg_smartcard), .cfg_irda(cfg_irda),
        .cfg_keep_echo(cfg_keep_echo), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_frame_err(rx_frame_err), .rx_pin(rx_pin), .line_in(line_in),
        .line_out(line_out), .line_oe(line_oe), .cfg_err(cfg_err),
        .tx_collision(tx_collision), .tx_active(tx_active), .rx_active(rx_active)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            if (fails < 20) $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Per-cycle reference of the pad, compared away from the active edge.
    always @(negedge clk) begin
        logic bad, eo, ev;
        int   n;
        if (rst) begin
            mt = -1;
        end else begin
            bad = cfg_half && (cfg_lin || cfg_clk_out || cfg_smartcard || cfg_irda);
            if (mt >= 0) begin
                n  = mt / B;
                ev = (n == 0) ? 1'b0 : (n <= 8) ? md[n-1] : 1'b1;
                eo = !bad;
                check(!tx_ready, "R1 ready while busy", tx_ready, 0);
            end else begin
                ev = 1'b1;
                eo = cfg_half ? 1'b0 : 1'b1;
            end
            if (cfg_half) check(line_oe == eo, "R4 line_oe", line_oe, eo);
            else          check(line_oe == eo, "R1 line_oe", line_oe, eo);
            if (bad)      check(!line_oe && !tx_ready, "R5 released", line_oe, 0);
            if (line_oe)  check(line_out == ev, "R1 line_out", line_out, ev);
            if (mt >= 0) begin
                mt = mt + 1;
                if (mt == 10 * B) mt = -1;
            end else if (tx_valid && tx_ready) begin
                if (cfg_half && ext_phase >= 1 && ext_phase <= 8)
                    check(1'b0, "R7 accepted during far-end frame", ext_phase, -1);
                mt = 0;
                md = tx_data;
            end
            if (tx_collision) col_cnt++;
            if (tx_collision && !cfg_half) check(1'b0, "R8 collision in full mode", 1, 0);
            if (rx_frame_err) fe_cnt++;
            if (rx_valid) begin
                rx_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, {rx_tag, " unexpected byte"}, rx_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rx_data == e, {rx_tag, " rx_data"}, rx_data, e);
                end
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(posedge clk); #2;
        tx_data  = b;
        tx_valid = 1'b1;
        do @(negedge clk); while (!tx_ready);
        @(posedge clk); #2;
        tx_valid = 1'b0;
    endtask

    task automatic ext_send(input logic [7:0] b, input logic stop_ok);
        @(posedge clk); #2;
        for (int i = 0; i < 10; i++) begin
            ext_phase = i;
            ext_line  = (i == 0) ? 1'b0 : (i <= 8) ? b[i-1] : stop_ok;
            repeat (B) @(posedge clk);
            #2;
        end
        ext_line  = 1'b1;
        ext_phase = -1;
    endtask

    task automatic settle();
        repeat (3 * B) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        int c0, r0, f0;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(line_oe == 1'b1, "R10 line_oe", line_oe, 1);
        check(line_out == 1'b1, "R10 line_out", line_out, 1);
        check(tx_ready == 1'b1, "R10 tx_ready", tx_ready, 1);
        check(!rx_valid && !tx_collision && !cfg_err, "R10 strobes", rx_valid, 0);

        // R2: full duplex loopback through rx_pin while line_in is held low
        loop_full = 1'b1;
        ext_line  = 1'b0;
        rx_tag    = "R2";
        exp_q.push_back(8'hA5); send(8'hA5);
        exp_q.push_back(8'h3C); send(8'h3C);
        repeat (10 * B + 20) @(posedge clk);
        check(rx_cnt == 2, "R2 bytes via rx_pin", rx_cnt, 2);
        check(col_cnt == 0, "R8 no collision in full mode", col_cnt, 0);
        ext_line = 1'b1;
        loop_full = 1'b0;
        // R5: conflicting enables do nothing in full duplex
        cfg_lin = 1'b1;
        @(negedge clk);
        check(cfg_err == 1'b0, "R5 full mode no error", cfg_err, 0);
        cfg_lin = 1'b0;
        settle();

        // switch to shared line; rx_pin held low and must be ignored (R3)
        rx_pin_drv = 1'b0;
        cfg_half   = 1'b1;
        settle();
        @(negedge clk);
        check(line_oe == 1'b0, "R4 released in idle", line_oe, 0);
        check(rx_cnt == 2, "R3 rx_pin ignored", rx_cnt, 2);

        // R6: echo kept
        cfg_keep_echo = 1'b1;
        rx_tag = "R6";
        exp_q.push_back(8'h5A); send(8'h5A);
        repeat (10 * B + 20) @(posedge clk);
        check(rx_cnt == 3, "R6 echo delivered", rx_cnt, 3);
        check(col_cnt == 0, "R8 clean echo", col_cnt, 0);

        // R6: echo dropped
        cfg_keep_echo = 1'b0;
        send(8'h96);
        repeat (10 * B + 20) @(posedge clk);
        check(rx_cnt == 3, "R6 echo discarded", rx_cnt, 3);

        // R3 / R7: far-end frame on the shared line
        rx_tag = "R3";
        exp_q.push_back(8'hC3);
        fork
            ext_send(8'hC3, 1'b1);
            begin
                repeat (3 * B) @(negedge clk);
                check(tx_ready == 1'b0, "R7 ready low while receiving", tx_ready, 0);
            end
        join
        settle();
        check(rx_cnt == 4, "R3 far-end byte", rx_cnt, 4);

        // R7: request made during a far-end frame waits for the receiver
        exp_q.push_back(8'h0F);
        fork
            ext_send(8'h0F, 1'b1);
            begin
                repeat (2 * B) @(posedge clk);
                send(8'h81);
            end
        join
        repeat (10 * B + 20) @(posedge clk);
        check(rx_cnt == 5, "R7 far-end byte then deferred send", rx_cnt, 5);

        // R9: bad stop bit
        f0 = fe_cnt; r0 = rx_cnt;
        ext_send(8'h55, 1'b0);
        settle();
        check(fe_cnt == f0 + 1, "R9 frame error strobe", fe_cnt - f0, 1);
        check(rx_cnt == r0, "R9 no byte on bad stop", rx_cnt - r0, 0);

        // R8: forced low during a one bit
        c0 = col_cnt;
        fork
            send(8'hFF);
            begin
                do @(negedge clk); while (!line_oe);
                repeat (3 * B) @(negedge clk);
                ext_line = 1'b0;
                repeat (B) @(negedge clk);
                ext_line = 1'b1;
            end
        join
        repeat (10 * B + 20) @(posedge clk);
        check(col_cnt == c0 + 1, "R8 one collision", col_cnt - c0, 1);

        // R5: conflicting mode with shared line
        @(posedge clk); #2;
        cfg_lin  = 1'b1;
        tx_data  = 8'h11;
        tx_valid = 1'b1;
        @(negedge clk);
        check(cfg_err == 1'b1, "R5 lin conflict", cfg_err, 1);
        check(tx_ready == 1'b0, "R5 ready blocked", tx_ready, 0);
        repeat (40) @(posedge clk);
        #2 tx_valid = 1'b0;
        cfg_lin  = 1'b0;
        cfg_irda = 1'b1;
        @(negedge clk);
        check(cfg_err == 1'b1 && line_oe == 1'b0, "R5 irda conflict", cfg_err, 1);
        cfg_irda = 1'b0;
        @(negedge clk);
        check(cfg_err == 1'b0 && tx_ready == 1'b1, "R5 cleared", cfg_err, 0);

        settle();
        check(exp_q.size() == 0, "R6 all expected bytes seen", exp_q.size(), 0);
        summary();
    end
endmodule